// File: doc/BRIEF.md
# Packed Integer SIMD ALU

This block is a 64-bit packed-integer execution unit. Each operand is a group of equal-width lanes: eight bytes, four 16-bit words, two 32-bit doublewords or one 64-bit quadword. Lane 0 sits in the least significant bits. One opcode selects the operation for the whole group. The operations are lane-wise add, subtract and equality compare, high and low interleave-unpack, gathering the sign bits of the bytes into a mask, unsigned rounding average, and extracting or inserting a 16-bit word chosen by an immediate.

The operation is computed combinationally. Its result is captured in an output register one clock after the input strobe. An opcode, or an opcode and lane-size pair, that has no defined meaning gives a zero result and raises an error flag.

Top module: `packed_alu`

## Requirements
- R1: With opcode 0 (add), each lane is the sum of the A and B lanes modulo its width. laneSel encodes the lane width as 0 for 8 bits, 1 for 16, 2 for 32 and 3 for 64, and no carry passes into the next lane.
- R2: With opcode 1 (subtract), each lane is A minus B modulo its width, at the lane width chosen by laneSel. No borrow passes between lanes.
- R3: With opcode 2 (compare), each lane at the width chosen by laneSel is all ones if the A and B lanes are equal, and all zeros otherwise.
- R4: Opcode 3 interleaves the upper halves of A and B and opcode 4 interleaves the lower halves. The element size is 8, 16 or 32 bits for laneSel 0, 1 or 2. Result element 2k comes from A and element 2k+1 comes from B, both taken from the k-th element of the chosen half.
- R5: With opcode 5 (sign mask), result bit i is bit 7 of byte i of A for i = 0..7. All higher result bits are zero, and laneSel has no effect.
- R6: With opcode 6 (average), each unsigned lane is (a + b + 1) >> 1, computed without overflow. The lanes are bytes for laneSel 0 and words for laneSel 1.
- R7: With opcode 7 (word extract), the result is the 16-bit word of A at index imm[1:0], zero-extended to 64 bits. imm[7:2] is ignored.
- R8: With opcode 8 (word insert), the result is A with its word at index imm[1:0] replaced by B[15:0]. imm[7:2] is ignored.
- R9: outValid is high exactly in the cycle after a cycle with inValid high. result and badOp are loaded only on such a strobe, and they hold their values otherwise.
- R10: Opcodes 9 to 15, unpack with laneSel 3, and average with laneSel 2 or 3 all produce result 0 with badOp 1. Every defined operation produces badOp 0.
- R11: While rstN is low, outValid, result and badOp are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Strobe that qualifies the operation inputs |
| opcode | input | 4 | Operation select |
| laneSel | input | 2 | Lane width: 0=8, 1=16, 2=32, 3=64 bits |
| imm | input | 8 | Word index for extract and insert (low 2 bits used) |
| opA | input | 64 | First operand |
| opB | input | 64 | Second operand |
| outValid | output | 1 | Result strobe, one cycle after inValid |
| result | output | 64 | Registered result |
| badOp | output | 1 | Registered flag for an undefined operation |

## Verification
The properties assume that opcode is held stable for the cycle in which inValid is sampled, because the checks on result shape use the opcode from the previous cycle. They also assume that reset is held long enough for the output register to clear. The bench changes inputs only at the falling edge and keeps each operation on the inputs for one full cycle. It also scrambles the inputs during idle cycles, which shows that the held result does not depend on what is on the inputs when no strobe is given.

// File: rtl/packed_alu_pkg.sv
package packed_alu_pkg;

  localparam int OPC_W  = 4;
  localparam int LANE_W = 2;

  typedef enum logic [OPC_W-1:0] {
    OP_ADD    = 4'd0,
    OP_SUB    = 4'd1,
    OP_CMPEQ  = 4'd2,
    OP_UNPKHI = 4'd3,
    OP_UNPKLO = 4'd4,
    OP_SMASK  = 4'd5,
    OP_AVG    = 4'd6,
    OP_WEXT   = 4'd7,
    OP_WINS   = 4'd8
  } opcode_e;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic              doArith;
    logic              doSub;
    logic              doCmp;
    logic              doUnpack;
    logic              unpackHi;
    logic              doMask;
    logic              doAvg;
    logic              avgWord;
    logic              doExtract;
    logic              doInsert;
    logic              bad;
    logic [LANE_W-1:0] laneSel;
  } ctrl_t;

endpackage

// File: rtl/packed_alu_ctrl.sv
module packed_alu_ctrl
  import packed_alu_pkg::*;
(
  input  logic [OPC_W-1:0]  opcode,
  input  logic [LANE_W-1:0] laneSel,
  output ctrl_t             ctrl
);

  always_comb begin
    ctrl = '0;
    ctrl.laneSel = laneSel;
    case (opcode)
      OP_ADD:   ctrl.doArith = 1'b1;
      OP_SUB: begin
        ctrl.doArith = 1'b1;
        ctrl.doSub   = 1'b1;
      end
      OP_CMPEQ: ctrl.doCmp = 1'b1;
      OP_UNPKHI, OP_UNPKLO: begin
        // A 64-bit element has no interleave partner inside the operand
        if (laneSel == 2'd3) begin
          ctrl.bad = 1'b1;
        end else begin
          ctrl.doUnpack = 1'b1;
          ctrl.unpackHi = (opcode == OP_UNPKHI);
        end
      end
      OP_SMASK: ctrl.doMask = 1'b1;
      OP_AVG: begin
        if (laneSel[1]) begin
          ctrl.bad = 1'b1;
        end else begin
          ctrl.doAvg   = 1'b1;
          ctrl.avgWord = laneSel[0];
        end
      end
      OP_WEXT: ctrl.doExtract = 1'b1;
      OP_WINS: ctrl.doInsert  = 1'b1;
      default: ctrl.bad = 1'b1;
    endcase
  end

endmodule

// File: rtl/packed_alu_datapath.sv
module packed_alu_datapath
  import packed_alu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 8
) (
  input  ctrl_t              ctrl,
  input  logic [DATA_W-1:0]  opA,
  input  logic [DATA_W-1:0]  opB,
  input  logic [IMM_W-1:0]   imm,
  output logic [DATA_W-1:0]  res
);

  localparam int NB     = DATA_W / 8;
  localparam int NW     = DATA_W / 16;
  localparam int WIDX_W = $clog2(NW);

  // Bytes-per-lane minus one, used to find lane boundaries
  logic [7:0] laneMask;
  assign laneMask = 8'((9'd1 << ctrl.laneSel) - 9'd1);

  // ---------------- add / subtract with a segmented carry chain
  logic [DATA_W-1:0] addB;
  logic [DATA_W-1:0] sumRes;
  logic [NB-2:0]     carry;

  assign addB = ctrl.doSub ? ~opB : opB;

  for (genvar i = 0; i < NB; i++) begin : g_byte
    logic cin;
    if (i == 0) begin : g_first
      assign cin = ctrl.doSub;
    end else begin : g_rest
      logic laneStart;
      assign laneStart = ((8'(i) & laneMask) == 8'd0);
      assign cin = laneStart ? ctrl.doSub : carry[i-1];
    end
    if (i < NB - 1) begin : g_mid
      assign {carry[i], sumRes[i*8 +: 8]} =
        {1'b0, opA[i*8 +: 8]} + {1'b0, addB[i*8 +: 8]} + 9'(cin);
    end else begin : g_top
      assign sumRes[i*8 +: 8] = opA[i*8 +: 8] + addB[i*8 +: 8] + 8'(cin);
    end
  end

  // ---------------- equality compare
  logic [NB-1:0]     eqByte;
  logic [DATA_W-1:0] cmpRes;
  logic              groupEq;

  for (genvar i = 0; i < NB; i++) begin : g_eq
    assign eqByte[i] = (opA[i*8 +: 8] == opB[i*8 +: 8]);
  end

  always_comb begin
    cmpRes  = '0;
    groupEq = 1'b1;
    for (int i = 0; i < NB; i++) begin
      groupEq = 1'b1;
      for (int j = 0; j < NB; j++) begin
        if (((i ^ j) & int'(laneMask)) == (i ^ j)) begin
          groupEq = groupEq & eqByte[j];
        end
      end
      cmpRes[i*8 +: 8] = {8{groupEq}};
    end
  end

  // ---------------- interleave-unpack
  logic [DATA_W-1:0] unpRes;

  always_comb begin
    unpRes = '0;
    for (int p = 0; p < NB; p++) begin
      int elemIdx;
      int srcElem;
      int srcByte;
      elemIdx = p >> ctrl.laneSel;
      srcElem = (elemIdx >> 1) + (ctrl.unpackHi ? ((NB >> ctrl.laneSel) >> 1) : 0);
      srcByte = (srcElem << ctrl.laneSel) + (p & int'(laneMask));
      if (elemIdx[0]) unpRes[p*8 +: 8] = opB[srcByte*8 +: 8];
      else            unpRes[p*8 +: 8] = opA[srcByte*8 +: 8];
    end
  end

  // ---------------- sign-bit mask
  logic [NB-1:0] signBits;
  for (genvar i = 0; i < NB; i++) begin : g_sign
    assign signBits[i] = opA[i*8 + 7];
  end

  // ---------------- rounding average
  logic [DATA_W-1:0] avgByte;
  logic [DATA_W-1:0] avgWordRes;

  for (genvar i = 0; i < NB; i++) begin : g_avgb
    logic [8:0] wide;
    assign wide = {1'b0, opA[i*8 +: 8]} + {1'b0, opB[i*8 +: 8]} + 9'd1;
    assign avgByte[i*8 +: 8] = wide[8:1];
  end

  for (genvar i = 0; i < NW; i++) begin : g_avgw
    logic [16:0] wide;
    assign wide = {1'b0, opA[i*16 +: 16]} + {1'b0, opB[i*16 +: 16]} + 17'd1;
    assign avgWordRes[i*16 +: 16] = wide[16:1];
  end

  // ---------------- word extract / insert
  logic [WIDX_W-1:0] wordIdx;
  logic [DATA_W-1:0] extRes;
  logic [DATA_W-1:0] insRes;

  assign wordIdx = WIDX_W'(imm % IMM_W'(NW));

  always_comb begin
    extRes = DATA_W'(opA[wordIdx*16 +: 16]);
    insRes = opA;
    insRes[wordIdx*16 +: 16] = opB[15:0];
  end

  // ---------------- result select
  always_comb begin
    res = '0;
    if      (ctrl.bad)       res = '0;
    else if (ctrl.doArith)   res = sumRes;
    else if (ctrl.doCmp)     res = cmpRes;
    else if (ctrl.doUnpack)  res = unpRes;
    else if (ctrl.doMask)    res = DATA_W'(signBits);
    else if (ctrl.doAvg)     res = ctrl.avgWord ? avgWordRes : avgByte;
    else if (ctrl.doExtract) res = extRes;
    else if (ctrl.doInsert)  res = insRes;
  end

endmodule

// File: rtl/packed_alu.sv
module packed_alu
  import packed_alu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [LANE_W-1:0] laneSel,
  input  logic [IMM_W-1:0]  imm,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic              badOp
);

  ctrl_t             ctrl;
  logic [DATA_W-1:0] dpRes;

  packed_alu_ctrl i_ctrl (
    .opcode (opcode),
    .laneSel(laneSel),
    .ctrl   (ctrl)
  );

  packed_alu_datapath #(
    .DATA_W(DATA_W),
    .IMM_W (IMM_W)
  ) i_dp (
    .ctrl(ctrl),
    .opA (opA),
    .opB (opB),
    .imm (imm),
    .res (dpRes)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      result   <= '0;
      badOp    <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        result <= dpRes;
        badOp  <= ctrl.bad;
      end
    end
  end

endmodule

// File: rtl/packed_alu_checker.sv
module packed_alu_checker
  import packed_alu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [OPC_W-1:0]  opcode,
  input logic              outValid,
  input logic [DATA_W-1:0] result,
  input logic              badOp
);

  function automatic logic bytesSolid(input logic [DATA_W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < DATA_W / 8; i++) begin
      if (v[i*8 +: 8] != 8'h00 && v[i*8 +: 8] != 8'hFF) ok = 1'b0;
    end
    return ok;
  endfunction

  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R9
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(result) && $stable(badOp)));

  // R10
  bad_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && badOp) |-> (result == '0));

  // R5
  mask_upper_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(opcode) == OP_SMASK) |-> (result[DATA_W-1:8] == '0));

  // R7
  extract_upper_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(opcode) == OP_WEXT) |-> (result[DATA_W-1:16] == '0));

  // R3
  cmp_solid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(opcode) == OP_CMPEQ) |-> bytesSolid(result));

endmodule

bind packed_alu packed_alu_checker #(.DATA_W(DATA_W)) i_chk (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .opcode  (opcode),
  .outValid(outValid),
  .result  (result),
  .badOp   (badOp)
);

// File: tb/test_packed_alu.sv
`timescale 1ns/1ps
module test_packed_alu;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [3:0]  opcode = '0;
  logic [1:0]  laneSel = '0;
  logic [7:0]  imm = '0;
  logic [63:0] opA = '0;
  logic [63:0] opB = '0;
  logic        outValid;
  logic [63:0] result;
  logic        badOp;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  packed_alu i_packed_alu (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opcode(opcode),
    .laneSel(laneSel), .imm(imm), .opA(opA), .opB(opB),
    .outValid(outValid), .result(result), .badOp(badOp)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [3:0]  op;
    logic [1:0]  lane;
    logic [7:0]  imm;
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] exp;
    logic        err;
  } vec_t;

  localparam int NV = 33;
  localparam logic [210:0] VECS [NV] = '{
    // R1 add at four lane widths
    {4'd1, 4'd0, 2'd0, 8'h00, 64'h0000_0001_FFFF_FFFF, 64'h0000_0000_0000_0001, 64'h0000_0001_FFFF_FF00, 1'b0},
    {4'd1, 4'd0, 2'd1, 8'h00, 64'h0000_0001_FFFF_FFFF, 64'h0000_0000_0000_0001, 64'h0000_0001_FFFF_0000, 1'b0},
    {4'd1, 4'd0, 2'd2, 8'h00, 64'h0000_0001_FFFF_FFFF, 64'h0000_0000_0000_0001, 64'h0000_0001_0000_0000, 1'b0},
    {4'd1, 4'd0, 2'd3, 8'h00, 64'h0000_0001_FFFF_FFFF, 64'h0000_0000_0000_0001, 64'h0000_0002_0000_0000, 1'b0},
    // R2 subtract, borrow contained per lane
    {4'd2, 4'd1, 2'd0, 8'h00, 64'h0, 64'h1, 64'h0000_0000_0000_00FF, 1'b0},
    {4'd2, 4'd1, 2'd1, 8'h00, 64'h0, 64'h1, 64'h0000_0000_0000_FFFF, 1'b0},
    {4'd2, 4'd1, 2'd2, 8'h00, 64'h0, 64'h1, 64'h0000_0000_FFFF_FFFF, 1'b0},
    {4'd2, 4'd1, 2'd3, 8'h00, 64'h0, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0},
    {4'd2, 4'd1, 2'd0, 8'h00, 64'h1020_3040_5060_7080, 64'h0110_0220_0330_0440, 64'h0F10_2E20_4D30_6C40, 1'b0},
    // R3 compare
    {4'd3, 4'd2, 2'd0, 8'h00, 64'h1122_3344_5566_7788, 64'h1100_3300_5500_7700, 64'hFF00_FF00_FF00_FF00, 1'b0},
    {4'd3, 4'd2, 2'd1, 8'h00, 64'h1122_3344_5566_7788, 64'h1100_3300_5500_7700, 64'h0, 1'b0},
    {4'd3, 4'd2, 2'd1, 8'h00, 64'h1234_0000_ABCD_FFFF, 64'h1234_0001_ABCD_FFFF, 64'hFFFF_0000_FFFF_FFFF, 1'b0},
    {4'd3, 4'd2, 2'd2, 8'h00, 64'h1234_0000_ABCD_FFFF, 64'h1234_0001_ABCD_FFFF, 64'h0000_0000_FFFF_FFFF, 1'b0},
    {4'd3, 4'd2, 2'd3, 8'h00, 64'h1234_0000_ABCD_FFFF, 64'h1234_0001_ABCD_FFFF, 64'h0, 1'b0},
    // R4 unpack high / low
    {4'd4, 4'd3, 2'd0, 8'h00, 64'h7766_5544_3322_1100, 64'hFFEE_DDCC_BBAA_9988, 64'hFF77_EE66_DD55_CC44, 1'b0},
    {4'd4, 4'd4, 2'd0, 8'h00, 64'h7766_5544_3322_1100, 64'hFFEE_DDCC_BBAA_9988, 64'hBB33_AA22_9911_8800, 1'b0},
    {4'd4, 4'd3, 2'd1, 8'h00, 64'h7766_5544_3322_1100, 64'hFFEE_DDCC_BBAA_9988, 64'hFFEE_7766_DDCC_5544, 1'b0},
    {4'd4, 4'd4, 2'd1, 8'h00, 64'h7766_5544_3322_1100, 64'hFFEE_DDCC_BBAA_9988, 64'hBBAA_3322_9988_1100, 1'b0},
    {4'd4, 4'd3, 2'd2, 8'h00, 64'h7766_5544_3322_1100, 64'hFFEE_DDCC_BBAA_9988, 64'hFFEE_DDCC_7766_5544, 1'b0},
    {4'd4, 4'd4, 2'd2, 8'h00, 64'h7766_5544_3322_1100, 64'hFFEE_DDCC_BBAA_9988, 64'hBBAA_9988_3322_1100, 1'b0},
    // R5 sign mask, laneSel ignored
    {4'd5, 4'd5, 2'd0, 8'h00, 64'h807F_FF00_8101_C040, 64'h0, 64'h0000_0000_0000_00AA, 1'b0},
    {4'd5, 4'd5, 2'd3, 8'h00, 64'h807F_FF00_8101_C040, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_00AA, 1'b0},
    // R6 average, round up
    {4'd6, 4'd6, 2'd0, 8'h00, 64'hFF00_0102_FE80_0010, 64'hFF01_0105_FF7F_0020, 64'hFF01_0104_FF80_0018, 1'b0},
    {4'd6, 4'd6, 2'd1, 8'h00, 64'hFF00_0102_FE80_0010, 64'hFF01_0105_FF7F_0020, 64'hFF01_0104_FF00_0018, 1'b0},
    // R7 word extract
    {4'd7, 4'd7, 2'd0, 8'h02, 64'h4444_3333_2222_1111, 64'h0, 64'h0000_0000_0000_3333, 1'b0},
    {4'd7, 4'd7, 2'd0, 8'hFF, 64'h4444_3333_2222_1111, 64'h0, 64'h0000_0000_0000_4444, 1'b0},
    {4'd7, 4'd7, 2'd2, 8'h05, 64'h4444_3333_2222_1111, 64'h0, 64'h0000_0000_0000_2222, 1'b0},
    // R8 word insert
    {4'd8, 4'd8, 2'd0, 8'h01, 64'h4444_3333_2222_1111, 64'hDEAD_BEEF_0000_ABCD, 64'h4444_3333_ABCD_1111, 1'b0},
    {4'd8, 4'd8, 2'd1, 8'h07, 64'h4444_3333_2222_1111, 64'hDEAD_BEEF_0000_ABCD, 64'hABCD_3333_2222_1111, 1'b0},
    // R10 undefined operations
    {4'd10, 4'hF, 2'd0, 8'h00, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 64'h0, 1'b1},
    {4'd10, 4'h9, 2'd0, 8'h00, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 64'h0, 1'b1},
    {4'd10, 4'd3, 2'd3, 8'h00, 64'h7766_5544_3322_1100, 64'hFFEE_DDCC_BBAA_9988, 64'h0, 1'b1},
    {4'd10, 4'd6, 2'd2, 8'h00, 64'hFF00_0102_FE80_0010, 64'hFF01_0105_FF7F_0020, 64'h0, 1'b1}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    opcode  = v.op;
    laneSel = v.lane;
    imm     = v.imm;
    opA     = v.a;
    opB     = v.b;
    inValid = 1'b1;
  endtask

  task automatic checkVec(input vec_t v, input int k);
    chk($sformatf("R%0d vec%0d result", v.req, k), result, v.exp);
    chk($sformatf("R%0d vec%0d badOp", v.req, k), 64'(badOp), 64'(v.err));
    chk($sformatf("R9 vec%0d outValid", k), 64'(outValid), 64'd1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R9 watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    vec_t v;
    vec_t w;
    logic [63:0] held;
    // R11 reset state
    repeat (3) @(negedge clk);
    chk("R11 reset outValid", 64'(outValid), 64'd0);
    chk("R11 reset result", result, 64'd0);
    chk("R11 reset badOp", 64'(badOp), 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    // table walk, one operation followed by one idle cycle
    for (int k = 0; k < NV; k++) begin
      v = vec_t'(VECS[k]);
      drive(v);
      @(negedge clk);
      inValid = 1'b0;
      checkVec(v, k);
      @(negedge clk);
    end

    // R9 hold: idle cycles with scrambled inputs keep the last result
    v = vec_t'(VECS[0]);
    drive(v);
    @(negedge clk);
    inValid = 1'b0;
    held = result;
    opcode = 4'd1; opA = 64'hA5A5_A5A5_A5A5_A5A5; opB = 64'h5A5A; laneSel = 2'd2;
    @(negedge clk);
    chk("R9 idle outValid low", 64'(outValid), 64'd0);
    chk("R9 idle result held", result, held);
    opcode = 4'hE;
    @(negedge clk);
    chk("R9 idle badOp held", 64'(badOp), 64'd0);
    chk("R9 idle result still held", result, held);

    // R9 back-to-back strobes
    v = vec_t'(VECS[14]);
    w = vec_t'(VECS[29]);
    drive(v);
    @(negedge clk);
    drive(w);
    checkVec(v, 14);
    @(negedge clk);
    inValid = 1'b0;
    checkVec(w, 29);
    @(negedge clk);
    chk("R9 after burst outValid low", 64'(outValid), 64'd0);
    chk("R10 error flag held", 64'(badOp), 64'd1);

    // R11 reset mid-run clears the outputs
    v = vec_t'(VECS[7]);
    drive(v);
    @(negedge clk);
    rstN = 1'b0;
    #1;
    chk("R11 async reset result", result, 64'd0);
    chk("R11 async reset outValid", 64'(outValid), 64'd0);
    @(negedge clk);
    chk("R11 reset with strobe high", 64'(outValid), 64'd0);
    inValid = 1'b0;
    rstN = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule